// File: doc/BRIEF.md
# Video Sync Pulse Conditioner

This block conditions the horizontal sync, vertical sync and data-enable strobes of a parallel video stream before they are embedded in a serial link. It samples them once per pixel clock. With the width filter switched on, a change on horizontal sync or data enable reaches the output only after the new level has been seen on three consecutive samples. Shorter excursions are dropped as glitches. With the filter switched off, these two strobes pass unaltered. Vertical sync is never width-filtered. All three outputs carry the same fixed two-clock delay in both modes, so they stay aligned with each other and with pixel data that is delayed to match.

The block also watches how often each conditioned strobe toggles. Horizontal sync and data enable may toggle at most twice within any 130 consecutive pixel clocks. Vertical sync may toggle only once in that span, so its shortest legal pulse is 130 clocks. When a strobe breaks its limit, a per-strobe flag is raised. The flag stays set until reset or until a clear pulse is given.

Top module: `sf_sync_conditioner`

## Requirements
- R1: A clock edge with rst_n low drives hs_o, vs_o, de_o and all three violation flags low, and selects filtered mode regardless of filt_en_i.
- R2: In filtered mode, a new level on hs_i or de_i that lasts fewer than 3 consecutive samples never appears on hs_o or de_o.
- R3: In filtered mode, when hs_i or de_i holds a new level for 3 consecutive samples, the output takes that level at the edge that samples the third one, which is 2 clocks after the first.
- R4: In bypass mode, hs_o and de_o equal hs_i and de_i delayed by exactly 2 clocks, including pulses 1 clock wide.
- R5: vs_o equals vs_i delayed by exactly 2 clocks in both modes, and 1-clock pulses pass.
- R6: filt_en_i is registered, so the mode used at an edge is the value sampled at the previous edge. An edge that samples a changed filt_en_i restarts the stability run from the input sampled at that edge, so a filtered output cannot change at the following edge.
- R7: hs_viol_o (de_viol_o) sets one clock after hs_o (de_o) makes a third transition within 129 clocks of the first of the three. Three transitions spanning 130 clocks or more do not set it.
- R8: vs_viol_o sets one clock after vs_o makes a second transition within 129 clocks of the previous one. Transitions 130 clocks apart do not set it.
- R9: The flags are sticky. An edge that samples clr_flags_i high clears all three, and the clear wins over a set at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| filt_en_i | input | 1 | 1 selects the width filter, 0 selects bypass |
| clr_flags_i | input | 1 | Clears all violation flags when sampled high |
| hs_i | input | 1 | Raw horizontal sync |
| vs_i | input | 1 | Raw vertical sync |
| de_i | input | 1 | Raw data enable |
| hs_o | output | 1 | Conditioned horizontal sync |
| vs_o | output | 1 | Conditioned vertical sync |
| de_o | output | 1 | Conditioned data enable |
| hs_viol_o | output | 1 | Sticky rate violation flag for horizontal sync |
| vs_viol_o | output | 1 | Sticky rate violation flag for vertical sync |
| de_viol_o | output | 1 | Sticky rate violation flag for data enable |

## Verification
The hardest case to reach is the exact edge of the 130-clock window. Only transitions on the conditioned outputs count, so the stimulus places raw edges so that the conditioned transitions fall exactly 130 clocks apart (no flag) and exactly 129 clocks apart (flag). It does this for vertical sync alone and for a three-transition pattern on horizontal sync. A second awkward case is a mode change that lands right after a raw edge made in bypass. Here a plain three-sample comparison would let the output move one clock earlier than the restart rule allows. The stimulus raises hs_i one sample before filt_en_i returns high, and the scoreboard expects the output to hold for that extra clock.

// File: rtl/sf_pkg.sv
// Package: shared channel indices and vector type for the sync conditioner.
// Assumes: three strobes, with the index order used everywhere in the block.
package sf_pkg;
    localparam int NCH   = 3;
    localparam int CH_HS = 0;
    localparam int CH_VS = 1;
    localparam int CH_DE = 2;

    typedef logic [NCH-1:0] ch_vec_t;
endpackage

// File: rtl/sf_width_filter.sv
// Module: sf_width_filter
// Conditions one strobe. A fixed delay line of MIN_W-1 stages feeds the
// bypass path. When FILTER is set, a stability run counter also lets the
// output take a new level only after MIN_W equal consecutive samples, which
// gives the same MIN_W-1 clock latency as the bypass path.
// Assumes: MIN_W >= 2; mode_filt_i and restart_i come from the top-level
// mode register; rst_n is synchronous and active low.
module sf_width_filter #(
    parameter bit FILTER = 1'b1,
    parameter int MIN_W  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_filt_i,
    input  logic restart_i,
    input  logic raw_i,
    output logic cond_o
);
    localparam int DLY   = MIN_W - 1;
    localparam int RUN_W = (MIN_W > 2) ? $clog2(MIN_W) : 1;

    logic [DLY-1:0] pipe_q;
    logic           cond_q;

    // Alignment delay line used by the bypass path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= raw_i;
            for (int i = 1; i < DLY; i++) begin
                pipe_q[i] <= pipe_q[i-1];
            end
        end
    end

    generate
        if (FILTER) begin : g_filt
            logic             cand_q;
            logic [RUN_W-1:0] run_q;
            logic             settled;

            assign settled = (raw_i == cand_q) && (run_q >= RUN_W'(DLY - 1));

            // Track the candidate level and how long it has been held
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cand_q <= 1'b0;
                    run_q  <= '0;
                end else if (restart_i || (raw_i != cand_q)) begin
                    cand_q <= raw_i;
                    run_q  <= '0;
                end else if (run_q < RUN_W'(DLY - 1)) begin
                    run_q <= run_q + RUN_W'(1);
                end
            end

            // Output register: delayed copy in bypass, settled level in filter mode
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cond_q <= 1'b0;
                end else if (!mode_filt_i) begin
                    cond_q <= pipe_q[DLY-1];
                end else if (settled) begin
                    cond_q <= raw_i;
                end
            end

            if (MIN_W == 3) begin : g_chk
                // R2: in filter mode the output moves only onto a level seen on 3 samples
                p_short_dropped_r2: assert property (@(posedge clk) disable iff (!rst_n)
                    ($past(rst_n) && $past(mode_filt_i) && (cond_q != $past(cond_q)))
                    |-> ($past(raw_i, 1) == cond_q && $past(raw_i, 2) == cond_q
                         && $past(raw_i, 3) == cond_q));

                // R3: three equal samples with no restart in between are followed
                p_settled_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
                    ($past(rst_n, 1) && $past(rst_n, 2) && $past(rst_n, 3)
                     && $past(mode_filt_i) && !$past(restart_i, 2)
                     && $past(raw_i, 1) == $past(raw_i, 2)
                     && $past(raw_i, 2) == $past(raw_i, 3))
                    |-> (cond_q == $past(raw_i, 1)));

                // R4: bypass output is the raw input two clocks late
                p_bypass_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
                    ($past(rst_n, 1) && $past(rst_n, 2) && $past(rst_n, 3)
                     && !$past(mode_filt_i))
                    |-> (cond_q == $past(raw_i, 3)));
            end
        end else begin : g_pass
            logic unused_cfg;
            assign unused_cfg = mode_filt_i | restart_i;

            // Output register: delayed copy only, whatever the mode
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cond_q <= 1'b0;
                end else begin
                    cond_q <= pipe_q[DLY-1];
                end
            end

            if (MIN_W == 3) begin : g_chk
                // R5: the unfiltered strobe is always the raw input two clocks late
                p_vs_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
                    ($past(rst_n, 1) && $past(rst_n, 2) && $past(rst_n, 3))
                    |-> (cond_q == $past(raw_i, 3)));
            end
        end
    endgenerate

    assign cond_o = cond_q;
endmodule

// File: rtl/sf_rate_monitor.sv
// Module: sf_rate_monitor
// Counts transitions of one conditioned strobe over an exact sliding window
// of WIN clocks. A toggle history shift register supplies the value that
// leaves the window. A sticky flag sets when the count exceeds LIMIT.
// Assumes: WIN >= 2; sig_i is a registered signal; clr_i has priority over a set.
module sf_rate_monitor #(
    parameter int WIN   = 130,
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic sig_i,
    output logic flag_o
);
    localparam int CNT_W = $clog2(WIN + 1);

    logic             sig_d;
    logic             tr;
    logic [WIN-1:0]   hist_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             flag_q;

    assign tr      = sig_i ^ sig_d;
    assign cnt_nxt = cnt_q + CNT_W'(tr) - CNT_W'(hist_q[WIN-1]);

    // Window bookkeeping and sticky flag update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_d  <= 1'b0;
            hist_q <= '0;
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            sig_d  <= sig_i;
            hist_q <= {hist_q[WIN-2:0], tr};
            cnt_q  <= cnt_nxt;
            flag_q <= clr_i ? 1'b0 : (flag_q | (cnt_nxt > CNT_W'(LIMIT)));
        end
    end

    assign flag_o = flag_q;

    // R7: a flag rising without a clear just before needs a fresh transition
    p_flag_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag_q) && !$past(clr_i, 2)) |-> $past(tr));

    // R9: a set flag holds unless a clear was sampled
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag_q) && !$past(clr_i)) |-> flag_q);

    // R9: a sampled clear always leaves the flag low
    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i) |-> !flag_q);
endmodule

// File: rtl/sf_sync_conditioner.sv
// Module: sf_sync_conditioner (top)
// Registers the filter enable and builds one width-filter lane and one
// rate-monitor lane per strobe. Horizontal sync and data enable get the
// width filter; vertical sync gets only the alignment delay and a stricter
// transition limit.
// Assumes: one sample per pixel clock; rst_n is synchronous and active low.
module sf_sync_conditioner
    import sf_pkg::*;
#(
    parameter int WIN_CLKS    = 130,
    parameter int MIN_WIDTH   = 3,
    parameter int HSDE_MAX_TR = 2,
    parameter int VS_MAX_TR   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic filt_en_i,
    input  logic clr_flags_i,
    input  logic hs_i,
    input  logic vs_i,
    input  logic de_i,
    output logic hs_o,
    output logic vs_o,
    output logic de_o,
    output logic hs_viol_o,
    output logic vs_viol_o,
    output logic de_viol_o
);
    logic    en_q;
    logic    restart;
    ch_vec_t raw;
    ch_vec_t cond;
    ch_vec_t flag;

    assign raw[CH_HS] = hs_i;
    assign raw[CH_VS] = vs_i;
    assign raw[CH_DE] = de_i;

    // Mode register: filter on after reset, then follows the enable one clock late
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b1;
        end else begin
            en_q <= filt_en_i;
        end
    end

    assign restart = filt_en_i ^ en_q;

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            localparam bit IS_VS = (ch == CH_VS);

            sf_width_filter #(
                .FILTER (!IS_VS),
                .MIN_W  (MIN_WIDTH)
            ) u_filt (
                .clk         (clk),
                .rst_n       (rst_n),
                .mode_filt_i (en_q),
                .restart_i   (restart),
                .raw_i       (raw[ch]),
                .cond_o      (cond[ch])
            );

            sf_rate_monitor #(
                .WIN   (WIN_CLKS),
                .LIMIT (IS_VS ? VS_MAX_TR : HSDE_MAX_TR)
            ) u_rate (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr_i  (clr_flags_i),
                .sig_i  (cond[ch]),
                .flag_o (flag[ch])
            );
        end
    endgenerate

    assign hs_o      = cond[CH_HS];
    assign vs_o      = cond[CH_VS];
    assign de_o      = cond[CH_DE];
    assign hs_viol_o = flag[CH_HS];
    assign vs_viol_o = flag[CH_VS];
    assign de_viol_o = flag[CH_DE];

    // R1: leaving reset always lands in filtered mode
    p_default_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> en_q);
endmodule

// File: tb/tb_sf_sync_conditioner.sv
// Scoreboard bench. The driver task models the expected conditioned outputs
// from the requirements and queues them. A monitor pops and compares them
// after every clock edge. Flag behaviour is checked directly at set points.
module tb_sf_sync_conditioner;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic filt_en_i = 1'b1;
    logic clr_flags_i = 1'b0;
    logic hs_i = 1'b0;
    logic vs_i = 1'b0;
    logic de_i = 1'b0;
    logic hs_o, vs_o, de_o;
    logic hs_viol_o, vs_viol_o, de_viol_o;

    int checks = 0;
    int failures = 0;

    logic [2:0] qv[$];
    string      qt[$];

    logic [2:0] m_x1 = 3'b000;
    logic [2:0] m_x2 = 3'b000;
    logic [2:0] m_out = 3'b000;
    logic       m_en1 = 1'b1;
    logic       m_en2 = 1'b1;

    logic [2:0] mv;
    string      mt;

    always #4 clk = ~clk;

    sf_sync_conditioner dut (
        .clk(clk), .rst_n(rst_n), .filt_en_i(filt_en_i), .clr_flags_i(clr_flags_i),
        .hs_i(hs_i), .vs_i(vs_i), .de_i(de_i),
        .hs_o(hs_o), .vs_o(vs_o), .de_o(de_o),
        .hs_viol_o(hs_viol_o), .vs_viol_o(vs_viol_o), .de_viol_o(de_viol_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Driver: apply one sample and queue the outputs expected after its edge
    task automatic step(input logic h, input logic v, input logic d,
                        input logic e, input logic c, input string tag);
        logic [2:0] x0;
        logic [2:0] ex;
        @(negedge clk);
        hs_i = h; vs_i = v; de_i = d; filt_en_i = e; clr_flags_i = c;
        x0 = {d, v, h};
        for (int ch = 0; ch < 3; ch++) begin
            if (ch == 1 || !m_en1)
                ex[ch] = m_x2[ch];
            else if (x0[ch] == m_x1[ch] && m_x1[ch] == m_x2[ch] && m_en1 == m_en2)
                ex[ch] = x0[ch];
            else
                ex[ch] = m_out[ch];
        end
        m_out = ex;
        qv.push_back(ex);
        qt.push_back(tag);
        m_x2 = m_x1; m_x1 = x0;
        m_en2 = m_en1; m_en1 = e;
    endtask

    task automatic idle(input int n, input logic v, input logic e, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, v, 1'b0, e, 1'b0, tag);
    endtask

    task automatic chk_flags(input logic [2:0] e, input string tag);
        logic [2:0] a;
        a = {de_viol_o, vs_viol_o, hs_viol_o};
        chk(a == e, tag, int'(a), int'(e));
    endtask

    // Monitor: compare the outputs after each edge with the queued expectation
    always @(posedge clk) begin
        #2;
        if (qv.size() > 0) begin
            mv = qv.pop_front();
            mt = qt.pop_front();
            chk({de_o, vs_o, hs_o} == mv, mt, int'({de_o, vs_o, hs_o}), int'(mv));
        end
    end

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk({de_o, vs_o, hs_o} == 3'b000, "R1 outputs", int'({de_o, vs_o, hs_o}), 0);
        chk_flags(3'b000, "R1 flags");
        rst_n = 1'b1;
        idle(4, 1'b0, 1'b1, "R1");

        // R2: short HS and DE pulses are removed in filtered mode
        step(1, 0, 0, 1, 0, "R2"); idle(4, 0, 1, "R2");
        step(1, 0, 0, 1, 0, "R2"); step(1, 0, 0, 1, 0, "R2"); idle(4, 0, 1, "R2");
        step(0, 0, 1, 1, 0, "R2"); idle(4, 0, 1, "R2");
        step(0, 0, 1, 1, 0, "R2"); step(0, 0, 1, 1, 0, "R2"); idle(4, 0, 1, "R2");
        // R3: pulses of 3 and 4 samples pass with a 2-clock delay
        for (int i = 0; i < 4; i++) step(1, 0, 0, 1, 0, "R3");
        idle(4, 0, 1, "R3");
        for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 0, "R3");
        idle(140, 0, 1, "R3");
        // R2: a 1-sample dropout inside a DE pulse is bridged
        for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 0, "R2 dropout");
        step(0, 0, 0, 1, 0, "R2 dropout");
        for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 0, "R2 dropout");
        idle(6, 0, 1, "R2 dropout");
        chk_flags(3'b000, "R7 two transitions only");

        // R5: a 1-clock VS pulse passes in filtered mode; R8: it violates the VS rate
        step(0, 1, 0, 1, 0, "R5"); idle(6, 0, 1, "R5");
        chk_flags(3'b010, "R8 close VS transitions");
        idle(140, 0, 1, "R9");
        chk_flags(3'b010, "R9 sticky");
        step(0, 0, 0, 1, 1, "R9");
        step(0, 0, 0, 1, 0, "R9");
        chk_flags(3'b000, "R9 clear");

        // R4: bypass mode passes 1-clock pulses with a 2-clock delay
        idle(3, 0, 0, "R4");
        step(1, 0, 0, 0, 0, "R4"); idle(4, 0, 0, "R4");
        step(0, 0, 1, 0, 0, "R4"); idle(4, 0, 0, "R4");
        step(0, 1, 0, 0, 0, "R5 bypass"); idle(140, 0, 0, "R4");
        step(0, 0, 0, 0, 1, "R9"); step(0, 0, 0, 0, 0, "R9");
        chk_flags(3'b000, "R9 clear after bypass");

        // R6: HS rises one sample before filtering is re-enabled
        step(1, 0, 0, 0, 0, "R6");
        for (int i = 0; i < 6; i++) step(1, 0, 0, 1, 0, "R6");
        idle(140, 0, 1, "R6");

        // R8: VS transitions exactly 130 clocks apart do not violate
        for (int i = 0; i < 130; i++) step(0, 1, 0, 1, 0, "R5 long");
        idle(140, 0, 1, "R5 long");
        chk_flags(3'b000, "R8 130 apart");

        // R7: HS transitions at 0, 3 and 130 do not violate
        for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 0, "R7");
        idle(127, 0, 1, "R7");
        for (int i = 0; i < 20; i++) step(1, 0, 0, 1, 0, "R7");
        chk_flags(3'b000, "R7 span 130");
        idle(140, 0, 1, "R7");
        // R7: HS transitions at 0, 3 and 129 violate
        for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 0, "R7");
        idle(126, 0, 1, "R7");
        for (int i = 0; i < 6; i++) step(1, 0, 0, 1, 0, "R7");
        chk_flags(3'b001, "R7 HS span 129");
        idle(4, 0, 1, "R7");
        // R7: three quick DE transitions violate
        for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 0, "R7");
        idle(3, 0, 1, "R7");
        for (int i = 0; i < 6; i++) step(0, 0, 1, 1, 0, "R7");
        idle(3, 0, 1, "R7");
        chk_flags(3'b101, "R7 DE");

        // R8: VS transitions 129 clocks apart violate
        for (int i = 0; i < 129; i++) step(0, 1, 0, 1, 0, "R8");
        idle(6, 0, 1, "R8");
        chk_flags(3'b111, "R8 129 apart");

        // R9: flags persist, then clear together
        idle(140, 0, 1, "R9");
        chk_flags(3'b111, "R9 sticky all");
        step(0, 0, 0, 1, 1, "R9");
        step(0, 0, 0, 1, 0, "R9");
        chk_flags(3'b000, "R9 clear all");

        idle(4, 0, 1, "tail");
        repeat (3) @(negedge clk);
        report();
        $finish;
    end
endmodule